// File: doc/BRIEF.md
# Pointer-Stepped Integer Matrix Multiply Engine

This engine forms the product C = A × B of two square N-by-N matrices of signed 16-bit integers. Both matrices sit row-major in a memory that the engine reaches through a two-lane read port. Each lane returns its data one cycle after the request. The products go out through a separate write port. A one-cycle `start` pulse begins a run. `done` pulses once when the last result is out. Matrix size and the three base addresses are taken from inputs that the user holds steady for the whole run.

Each cycle of a run issues one A operand and one B operand. Each returned pair feeds a single multiply-accumulate into a 40-bit accumulator. Operand addresses come from running pointers and no index multiplication is done. Inside one dot product the A pointer steps by one and the B pointer steps by N. The row base is a register that grows by N whenever the row index advances. Issue runs one cycle ahead of accumulation, so one dot product follows another with no idle cycle.

Top module: `mat_mul_engine`

## Requirements
- R1: After reset, and whenever no run is in progress, `rd_en`, `wr_en` and `done` are low.
- R2: For N in 1..64, a run writes exactly N·N results. The result for row i, column j is the exact signed sum over k of A[i][k]·B[k][j], written to address `base_c` + i·N + j.
- R3: Operand (i,k) of A is read at `base_a` + i·N + k. Operand (k,j) of B is read at `base_b` + k·N + j.
- R4: A run issues reads on N·N·N consecutive cycles. The dot product for (i,j) takes N of them in order k = 0..N−1. Within it, `rd_addr_a` rises by 1 and `rd_addr_b` rises by N from one cycle to the next.
- R5: The engine uses `rd_data_a` and `rd_data_b` exactly one cycle after the cycle in which it raised `rd_en`.
- R6: `done` is high for exactly one cycle. Counting the clock edge that samples `start` as edge 0, `done` is first high after edge N·N·N + 2, one cycle after the last write.
- R7: Results are written in row-major order: j increases within a row, then i increases.
- R8: A `start` pulse while a run is in progress has no effect on the reads, the writes, the results or the timing of `done`.
- R9: Operands are two's complement. The accumulator holds sums up to 2^34 in magnitude, for example sixteen products of −32768·−32768, without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a run |
| n_size | input | 7 | Matrix dimension N, 1..64 |
| base_a | input | 16 | Address of A[0][0] |
| base_b | input | 16 | Address of B[0][0] |
| base_c | input | 16 | Address of C[0][0] |
| rd_en | output | 1 | Operand read request |
| rd_addr_a | output | 16 | A operand address |
| rd_addr_b | output | 16 | B operand address |
| rd_data_a | input | 16 | A operand, valid one cycle after the request |
| rd_data_b | input | 16 | B operand, valid one cycle after the request |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | 16 | Result address |
| wr_data | output | 40 | Signed result value |
| done | output | 1 | One-cycle pulse when the run has finished |

## Verification
A corrupted pointer or loop counter shows on the read address lanes in the same cycle. The bench logs every request and compares it with the closed-form row-major address, so a fault is caught at the first wrong read. A wrong accumulator clear or a misaligned pipeline flag only shows in the result written one cycle after the last operand of that dot product returns. Each written value and address is therefore checked against an independently computed product. A miscounted outer loop changes the write count and moves `done` away from cycle N·N·N + 2, which the bench measures exactly.

// File: rtl/mat_mul_engine.sv
module mat_mul_engine #(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int NW    = 7,
  parameter int ACC_W = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [NW-1:0]           n_size,
  input  logic [AW-1:0]           base_a,
  input  logic [AW-1:0]           base_b,
  input  logic [AW-1:0]           base_c,
  output logic                    rd_en,
  output logic [AW-1:0]           rd_addr_a,
  output logic [AW-1:0]           rd_addr_b,
  input  logic signed [DW-1:0]    rd_data_a,
  input  logic signed [DW-1:0]    rd_data_b,
  output logic                    wr_en,
  output logic [AW-1:0]           wr_addr,
  output logic signed [ACC_W-1:0] wr_data,
  output logic                    done
);

  localparam int PW = 2 * DW;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_t;
  state_t state;

  logic [NW-1:0] k_cnt, j_cnt, i_cnt;
  logic [AW-1:0] row_base, pa, pb;
  logic [AW-1:0] n_ext, j_ext;
  logic [NW-1:0] n_last;
  logic          k_end, j_end, i_end, issue;

  assign n_ext  = {{(AW-NW){1'b0}}, n_size};
  assign j_ext  = {{(AW-NW){1'b0}}, j_cnt};
  assign n_last = n_size - 1'b1;
  assign k_end  = (k_cnt == n_last);
  assign j_end  = (j_cnt == n_last);
  assign i_end  = (i_cnt == n_last);
  assign issue  = (state == S_RUN);

  assign rd_en     = issue;
  assign rd_addr_a = base_a + pa;
  assign rd_addr_b = base_b + pb;

  // Address walk: pointers only add 1 or N, row base only adds N.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      k_cnt    <= '0;
      j_cnt    <= '0;
      i_cnt    <= '0;
      row_base <= '0;
      pa       <= '0;
      pb       <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state    <= S_RUN;
          k_cnt    <= '0;
          j_cnt    <= '0;
          i_cnt    <= '0;
          row_base <= '0;
          pa       <= '0;
          pb       <= '0;
        end
        S_RUN: begin
          if (k_end) begin
            k_cnt <= '0;
            if (j_end) begin
              j_cnt <= '0;
              if (i_end) begin
                state <= S_DRAIN;
              end else begin
                i_cnt    <= i_cnt + 1'b1;
                row_base <= row_base + n_ext;
                pa       <= row_base + n_ext;
                pb       <= '0;
              end
            end else begin
              j_cnt <= j_cnt + 1'b1;
              pa    <= row_base;
              pb    <= j_ext + 1'b1;
            end
          end else begin
            k_cnt <= k_cnt + 1'b1;
            pa    <= pa + 1'b1;
            pb    <= pb + n_ext;
          end
        end
        S_DRAIN: if (done) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // Stage aligned with returning read data.
  logic          vld_q, first_q, last_q, fin_q, fin2_q;
  logic [AW-1:0] off_q;
  logic signed [PW-1:0]    prod;
  logic signed [ACC_W-1:0] acc, acc_nxt;

  assign prod    = rd_data_a * rd_data_b;
  assign acc_nxt = (first_q ? '0 : acc) + ACC_W'(prod);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      fin_q   <= 1'b0;
      fin2_q  <= 1'b0;
      off_q   <= '0;
      acc     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      done    <= 1'b0;
    end else begin
      vld_q   <= issue;
      first_q <= (k_cnt == '0);
      last_q  <= k_end;
      fin_q   <= k_end & j_end & i_end;
      off_q   <= row_base + j_ext;
      if (vld_q) acc <= acc_nxt;
      wr_en   <= vld_q & last_q;
      if (vld_q & last_q) begin
        wr_data <= acc_nxt;
        wr_addr <= base_c + off_q;
      end
      fin2_q  <= vld_q & last_q & fin_q;
      done    <= fin2_q;
    end
  end

  AST_A_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && k_cnt != '0) |-> rd_addr_a == $past(rd_addr_a) + 1'b1); // R4
  AST_B_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && k_cnt != '0) |-> rd_addr_b == $past(rd_addr_b) + n_ext); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (!rd_en && !wr_en && !done)); // R1
  AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en)); // R6

endmodule

// File: tb/mat_mul_engine_bench.sv
`timescale 1ns/1ps
module mat_mul_engine_bench;
  localparam int DW = 16, AW = 16, NW = 7, ACC_W = 40;
  localparam int MEM = 4096;

  logic clk = 0, rst_n = 0, start = 0;
  logic [NW-1:0] n_size = 1;
  logic [AW-1:0] base_a = 0, base_b = 0, base_c = 0;
  logic rd_en, wr_en, done;
  logic [AW-1:0] rd_addr_a, rd_addr_b, wr_addr;
  logic signed [DW-1:0] rd_data_a = 0, rd_data_b = 0;
  logic signed [ACC_W-1:0] wr_data;

  always #2 clk = ~clk;

  mat_mul_engine #(.DW(DW), .AW(AW), .NW(NW), .ACC_W(ACC_W)) u_mat_mul_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .n_size(n_size),
    .base_a(base_a), .base_b(base_b), .base_c(base_c),
    .rd_en(rd_en), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done));

  logic signed [DW-1:0] mem [MEM];
  logic [AW-1:0] rd_a_log [MEM];
  logic [AW-1:0] rd_b_log [MEM];
  logic [AW-1:0] wa_log [MEM];
  logic signed [ACC_W-1:0] wd_log [MEM];
  int rd_cnt = 0, wr_cnt = 0;
  logic log_clr = 0;

  always @(posedge clk) begin
    if (log_clr) begin
      rd_cnt = 0;
      wr_cnt = 0;
    end else begin
      if (rd_en) begin
        rd_data_a <= mem[rd_addr_a[11:0]];
        rd_data_b <= mem[rd_addr_b[11:0]];
        if (rd_cnt < MEM) begin
          rd_a_log[rd_cnt] = rd_addr_a;
          rd_b_log[rd_cnt] = rd_addr_b;
        end
        rd_cnt = rd_cnt + 1;
      end
      if (wr_en) begin
        if (wr_cnt < MEM) begin
          wa_log[wr_cnt] = wr_addr;
          wd_log[wr_cnt] = wr_data;
        end
        wr_cnt = wr_cnt + 1;
      end
    end
  end

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic signed [DW-1:0] fill(int mode, int seed, int idx, bit is_b);
    case (mode)
      1: return -16'sd32768;
      2: return is_b ? -16'sd32768 : 16'sd32767;
      default: return DW'(((idx * (seed + (is_b ? 4 : 0)) * 13 + seed * 5 + 3) % 511) - 255);
    endcase
  endfunction

  // {n, base_a, base_b, base_c, mode, seed}
  localparam int TBL [7][6] = '{
    '{1,    0,  100,  200, 0, 3},
    '{2,   10,   50,  300, 0, 5},
    '{3,    0,   16,  500, 0, 7},
    '{5,   40,  120,  600, 0, 11},
    '{16, 2000, 2300, 3000, 1, 0},
    '{8,   700,  800,  900, 2, 0},
    '{4,  1200, 1300, 1400, 0, 9}
  };

  task automatic run(input int n, input int ba, input int bb, input int bc,
                     input int mode, input int seed, input int extra_at);
    int cnt;
    int total;
    int rd_bad;
    longint exp;
    total = n * n * n;
    for (int x = 0; x < n * n; x++) begin
      mem[ba + x] = fill(mode, seed, x, 1'b0);
      mem[bb + x] = fill(mode, seed, x, 1'b1);
    end
    @(negedge clk);
    n_size = NW'(n); base_a = AW'(ba); base_b = AW'(bb); base_c = AW'(bc);
    log_clr = 1;
    @(negedge clk);
    log_clr = 0;
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    cnt = 0;
    while (!done && cnt < total + 50) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (extra_at != 0 && (cnt == extra_at || cnt == total + 1)) start = 1;
      else start = 0;
    end
    start = 0;
    check(cnt == total + 2, "R6", "done latency", cnt, total + 2);
    @(negedge clk);
    check(!done, "R6", "done width", done, 0);
    check(!rd_en && !wr_en, "R1", "idle quiet after run", {rd_en, wr_en}, 0);
    check(wr_cnt == n * n, "R2", "write count", wr_cnt, n * n);
    check(rd_cnt == total, "R4", "read count", rd_cnt, total);
    rd_bad = 0;
    for (int r = 0; r < total && r < MEM; r++) begin
      int e, k, i, j;
      e = r / n; k = r % n; i = e / n; j = e % n;
      if (rd_a_log[r] != AW'(ba + i * n + k) || rd_b_log[r] != AW'(bb + k * n + j)) begin
        if (rd_bad == 0)
          $display("FAIL R3 read %0d addr a/b actual %0d/%0d expected %0d/%0d",
                   r, rd_a_log[r], rd_b_log[r], ba + i * n + k, bb + k * n + j);
        rd_bad++;
      end
    end
    checks++;
    if (rd_bad != 0) fails++;
    for (int e = 0; e < n * n && e < wr_cnt; e++) begin
      int i, j;
      i = e / n; j = e % n;
      exp = 0;
      for (int k = 0; k < n; k++)
        exp += longint'(mem[ba + i * n + k]) * longint'(mem[bb + k * n + j]);
      check(wa_log[e] == AW'(bc + e), "R7", "write address", wa_log[e], bc + e);
      check(longint'(wd_log[e]) == exp, "R2 R5 R9", "result value", wd_log[e], exp);
    end
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual 1 expected 0");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!rd_en && !wr_en && !done, "R1", "reset outputs", {rd_en, wr_en, done}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!rd_en && !wr_en && !done, "R1", "idle after reset", {rd_en, wr_en, done}, 0);
    for (int t = 0; t < 6; t++)
      run(TBL[t][0], TBL[t][1], TBL[t][2], TBL[t][3], TBL[t][4], TBL[t][5], 0);
    // R8: extra start pulses mid-run and in the drain phase
    run(TBL[6][0], TBL[6][1], TBL[6][2], TBL[6][3], TBL[6][4], TBL[6][5], 5);
    // R8: back-to-back run after the ignored pulses still behaves
    run(3, 100, 200, 300, 0, 13, 2);
    finish_up();
  end
endmodule